// File: doc/BRIEF.md
# Multi-Format Pixel Bus Unpacker

This block sits between the serial output of a video memory and the colour lookup stage of a display pipeline. It accepts one 64-bit word at a time over a valid/ready handshake and emits one pixel per clock. A mode input chooses how the word is cut into pixels. In the pseudo-colour depths (1, 2, 4 or 8 bits per pixel) each pixel becomes an 8-bit palette index. In the packed colour layouts (four 16-bit formats and one 32-bit format) each pixel becomes separate red, green, blue and overlay bytes.

Fields narrower than a byte are widened by copying their top bits into the vacated low bits, so an all-ones field becomes 0xFF. For shallow pseudo-colour depths, a page input fills the upper index bits, so rewriting one register recolours the whole screen. A byte-order input chooses whether the first pixel comes from the bottom or the top of the word. The mode and the byte order are captured together with each word, so a setting changed mid-word only applies from the next word.

A three-state controller sequences the stream. The states are IDLE (after reset, no word yet), RUN (a word is streaming) and STALL (a word has run out and none was supplied in time). Its transitions are: IDLE to RUN on a load; RUN to RUN while pixels remain, or when the next word is loaded on the last pixel; RUN to STALL on the last pixel with no word offered; STALL to RUN on a load. The controller requests the next word while the last pixel of the current one is on the outputs. A word that arrives in time therefore follows with no gap.

Top module: `pixel_unpacker`

## Requirements
- R1: While reset is held and on the first cycle after it, word_ready is 1 and pix_valid and underrun are 0.
- R2: A word is loaded on a rising edge where word_valid and word_ready are both 1. Its first pixel is on the outputs with pix_valid high in the following cycle, and the word then yields one pixel per cycle.
- R3: cfg_mode codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel (64, 32, 16 and 8 pixels per word). Codes 4 to 7 select 16-bit pixels (4 per word). Code 8 selects 32-bit pixels (2 per word). Codes 9 to 15 behave as code 3. No pixel is output beyond the count for the loaded word.
- R4: With cfg_big_endian 0, pixel k of a word is taken from bits [k*w+w-1 : k*w], where w is the pixel width. With cfg_big_endian 1, the order is reversed, so the first pixel comes from the most significant w bits.
- R5: In pseudo-colour codes, pix_index is {cfg_page[7:w], pixel} for w of 1, 2 or 4, and the pixel itself for w of 8. pix_truecolor is 0 and the colour and overlay outputs are 0. In codes 4 to 8, pix_truecolor is 1 and pix_index is 0.
- R6: Code 4 layout: red [15:11], green [10:5], blue [4:0], overlay output 0. Each field is widened to 8 bits by repeating its top bits.
- R7: Code 5 layout: overlay [15] replicated to 8 bits, red [14:10], green [9:5], blue [4:0], widened as in R6.
- R8: Code 6 layout: red [15:10], green [9:4], blue [3:0], overlay output 0, widened as in R6.
- R9: Code 7 layout: overlay [15:12], red [11:8], green [7:4], blue [3:0], each 4-bit field doubled to 8 bits.
- R10: Code 8 layout: overlay [31:24], red [23:16], green [15:8], blue [7:0], passed through unchanged.
- R11: word_ready is 1 during the cycle the last pixel of a word is output. A word offered then is loaded on that edge, and its first pixel follows with no idle cycle and no underrun.
- R12: If the last pixel passes with no word loaded, pix_valid drops, underrun rises, and the colour and overlay outputs hold the last pixel's values until the next load.
- R13: A change of cfg_mode or cfg_big_endian after a word is loaded does not affect that word's pixels; the values present at the load are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A memory word is offered |
| word_data | input | 64 | Offered memory word |
| word_ready | output | 1 | The block can take a word this cycle |
| cfg_mode | input | 4 | Pixel format code, captured at each load |
| cfg_big_endian | input | 1 | 1 takes the first pixel from the top bits |
| cfg_page | input | 8 | Upper palette index bits for shallow depths |
| pix_valid | output | 1 | A pixel is on the outputs |
| pix_truecolor | output | 1 | 1 when the pixel carries colour components |
| pix_index | output | 8 | Palette index in pseudo-colour formats |
| pix_red | output | 8 | Widened red component |
| pix_green | output | 8 | Widened green component |
| pix_blue | output | 8 | Widened blue component |
| pix_ovl | output | 8 | Widened overlay field |
| underrun | output | 1 | The stream ran dry and the last pixel is held |

## Verification
In one cycle the last pixel of a word can be output while the next word is loaded, and that next word may carry a different format and byte order. The bench provokes this by offering words back to back with the format and byte order changed between them, and by altering cfg_mode just after a load. A scoreboard that predicted every pixel from the settings at its own load judges the result: each word must come out whole in its own format, with no idle cycle and no underrun at the joint.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    typedef enum logic [3:0] {
        FMT_P1   = 4'd0,
        FMT_P2   = 4'd1,
        FMT_P4   = 4'd2,
        FMT_P8   = 4'd3,
        FMT_565  = 4'd4,
        FMT_5551 = 4'd5,
        FMT_664  = 4'd6,
        FMT_4444 = 4'd7,
        FMT_888O = 4'd8
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } seq_state_e;

    // Map a raw mode code onto a format; unused codes fall back to 8-bit pseudo-colour.
    function automatic fmt_e norm_fmt(input logic [3:0] code);
        case (code)
            4'd0:    return FMT_P1;
            4'd1:    return FMT_P2;
            4'd2:    return FMT_P4;
            4'd4:    return FMT_565;
            4'd5:    return FMT_5551;
            4'd6:    return FMT_664;
            4'd7:    return FMT_4444;
            4'd8:    return FMT_888O;
            default: return FMT_P8;
        endcase
    endfunction

    // log2 of the pixel width in bits
    function automatic logic [2:0] fmt_log2(input fmt_e f);
        case (f)
            FMT_P1:   return 3'd0;
            FMT_P2:   return 3'd1;
            FMT_P4:   return 3'd2;
            FMT_P8:   return 3'd3;
            FMT_888O: return 3'd5;
            default:  return 3'd4;
        endcase
    endfunction

    function automatic logic [7:0] widen4(input logic [3:0] v);
        return {v, v};
    endfunction

    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

endpackage

// File: rtl/pxu_extract.sv
// Selects the current pixel's raw bits from the held word.
module pxu_extract
    import pxu_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  fmt_e              fmt,
    input  logic              big_end,
    input  logic [CNT_W-1:0]  cnt,
    output logic [31:0]       raw
);
    logic [2:0]        lg;
    logic [CNT_W-1:0]  n_last;
    logic [CNT_W-1:0]  slot;
    logic [CNT_W-1:0]  shamt;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        lg      = fmt_log2(fmt);
        n_last  = CNT_W'((WORD_W >> lg) - 1);
        slot    = big_end ? (n_last - cnt) : cnt;
        shamt   = slot << lg;
        shifted = word >> shamt;
        unique case (lg)
            3'd0:    raw = {31'b0, shifted[0]};
            3'd1:    raw = {30'b0, shifted[1:0]};
            3'd2:    raw = {28'b0, shifted[3:0]};
            3'd3:    raw = {24'b0, shifted[7:0]};
            3'd4:    raw = {16'b0, shifted[15:0]};
            default: raw = shifted[31:0];
        endcase
    end
endmodule

// File: rtl/pxu_fields.sv
// Splits a raw pixel into palette index or widened colour fields.
module pxu_fields
    import pxu_pkg::*;
(
    input  logic [31:0] raw,
    input  fmt_e        fmt,
    input  logic [7:0]  page,
    output logic        truecolor,
    output logic [7:0]  idx,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue,
    output logic [7:0]  ovl
);
    always_comb begin
        truecolor = 1'b1;
        idx   = 8'h00;
        red   = 8'h00;
        green = 8'h00;
        blue  = 8'h00;
        ovl   = 8'h00;
        unique case (fmt)
            FMT_P1: begin truecolor = 1'b0; idx = {page[7:1], raw[0]};   end
            FMT_P2: begin truecolor = 1'b0; idx = {page[7:2], raw[1:0]}; end
            FMT_P4: begin truecolor = 1'b0; idx = {page[7:4], raw[3:0]}; end
            FMT_P8: begin truecolor = 1'b0; idx = raw[7:0];              end
            FMT_565: begin
                red   = widen5(raw[15:11]);
                green = widen6(raw[10:5]);
                blue  = widen5(raw[4:0]);
            end
            FMT_5551: begin
                ovl   = {8{raw[15]}};
                red   = widen5(raw[14:10]);
                green = widen5(raw[9:5]);
                blue  = widen5(raw[4:0]);
            end
            FMT_664: begin
                red   = widen6(raw[15:10]);
                green = widen6(raw[9:4]);
                blue  = widen4(raw[3:0]);
            end
            FMT_4444: begin
                ovl   = widen4(raw[15:12]);
                red   = widen4(raw[11:8]);
                green = widen4(raw[7:4]);
                blue  = widen4(raw[3:0]);
            end
            FMT_888O: begin
                ovl   = raw[31:24];
                red   = raw[23:16];
                green = raw[15:8];
                blue  = raw[7:0];
            end
            default: begin truecolor = 1'b0; idx = raw[7:0]; end
        endcase
    end
endmodule

// File: rtl/pxu_seq.sv
// Word latch, pixel counter and IDLE/RUN/STALL controller.
module pxu_seq
    import pxu_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  fmt_e              cfg_fmt,
    input  logic              cfg_be,
    output logic              word_ready,
    output logic              pix_valid,
    output logic              underrun,
    output logic [WORD_W-1:0] cur_word,
    output fmt_e              act_fmt,
    output logic              act_be,
    output logic [CNT_W-1:0]  pix_cnt
);
    seq_state_e       state, state_nxt;
    logic [CNT_W-1:0] last_cnt;
    logic             at_last;
    logic             take;

    always_comb begin
        last_cnt = CNT_W'((WORD_W >> fmt_log2(act_fmt)) - 1);
        at_last  = (pix_cnt == last_cnt);
        take     = word_valid && word_ready;
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (take) state_nxt = ST_RUN;
            ST_RUN:   if (at_last) state_nxt = take ? ST_RUN : ST_STALL;
            ST_STALL: if (take) state_nxt = ST_RUN;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // word and counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_word <= '0;
            act_fmt  <= FMT_P8;
            act_be   <= 1'b0;
            pix_cnt  <= '0;
        end else if (take) begin
            cur_word <= word_data;
            act_fmt  <= cfg_fmt;
            act_be   <= cfg_be;
            pix_cnt  <= '0;
        end else if (state == ST_RUN && !at_last) begin
            pix_cnt  <= pix_cnt + 1'b1;
        end
    end

    // state-decoded outputs
    always_comb begin
        word_ready = 1'b1;
        pix_valid  = 1'b0;
        underrun   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_RUN:   begin pix_valid = 1'b1; word_ready = at_last; end
            ST_STALL: underrun = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
#(
    parameter int WORD_W = 64,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic [3:0]        cfg_mode,
    input  logic              cfg_big_endian,
    input  logic [7:0]        cfg_page,
    output logic              pix_valid,
    output logic              pix_truecolor,
    output logic [7:0]        pix_index,
    output logic [7:0]        pix_red,
    output logic [7:0]        pix_green,
    output logic [7:0]        pix_blue,
    output logic [7:0]        pix_ovl,
    output logic              underrun
);
    fmt_e              act_fmt;
    logic              act_be;
    logic [WORD_W-1:0] cur_word;
    logic [CNT_W-1:0]  pix_cnt;
    logic [31:0]       raw;

    pxu_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .cfg_fmt    (norm_fmt(cfg_mode)),
        .cfg_be     (cfg_big_endian),
        .word_ready (word_ready),
        .pix_valid  (pix_valid),
        .underrun   (underrun),
        .cur_word   (cur_word),
        .act_fmt    (act_fmt),
        .act_be     (act_be),
        .pix_cnt    (pix_cnt)
    );

    pxu_extract #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ext (
        .word    (cur_word),
        .fmt     (act_fmt),
        .big_end (act_be),
        .cnt     (pix_cnt),
        .raw     (raw)
    );

    pxu_fields u_fld (
        .raw       (raw),
        .fmt       (act_fmt),
        .page      (cfg_page),
        .truecolor (pix_truecolor),
        .idx       (pix_index),
        .red       (pix_red),
        .green     (pix_green),
        .blue      (pix_blue),
        .ovl       (pix_ovl)
    );
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       word_valid,
    input logic       word_ready,
    input logic       pix_valid,
    input logic       pix_truecolor,
    input logic [7:0] pix_index,
    input logic [7:0] pix_red,
    input logic [7:0] pix_green,
    input logic [7:0] pix_blue,
    input logic [7:0] pix_ovl,
    input logic       underrun
);
    // R2: a load is followed by a valid pixel
    p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> pix_valid);

    // R11: before the last pixel the stream keeps going
    p_mid_word_continues_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !word_ready) |=> (pix_valid && !underrun));

    // R12: last pixel with no word offered leads to underrun
    p_dry_enters_underrun_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && word_ready && !word_valid) |=> (underrun && !pix_valid));

    // R12: underrun never overlaps a valid pixel
    p_underrun_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !pix_valid);

    // R12: held components stay still while starved
    p_hold_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && $past(underrun)) |->
            ($stable(pix_red) && $stable(pix_green) && $stable(pix_blue) && $stable(pix_ovl)));

    // R5: colour outputs are zero in pseudo-colour and index is zero in colour modes
    p_kind_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_truecolor ? (pix_index == 8'h00)
                                     : ({pix_red, pix_green, pix_blue, pix_ovl} == 32'h0)));
endmodule

bind pixel_unpacker pxu_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_valid    (word_valid),
    .word_ready    (word_ready),
    .pix_valid     (pix_valid),
    .pix_truecolor (pix_truecolor),
    .pix_index     (pix_index),
    .pix_red       (pix_red),
    .pix_green     (pix_green),
    .pix_blue      (pix_blue),
    .pix_ovl       (pix_ovl),
    .underrun      (underrun)
);

// File: tb/sim_pixel_unpacker.sv
`timescale 1ns/1ps
module sim_pixel_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [63:0] word_data = '0;
    logic        word_ready;
    logic [3:0]  cfg_mode = 4'd3;
    logic        cfg_big_endian = 1'b0;
    logic [7:0]  cfg_page = 8'h00;
    logic        pix_valid, pix_truecolor, underrun;
    logic [7:0]  pix_index, pix_red, pix_green, pix_blue, pix_ovl;

    always #2.5 clk = ~clk;

    pixel_unpacker u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .cfg_mode(cfg_mode), .cfg_big_endian(cfg_big_endian),
        .cfg_page(cfg_page), .pix_valid(pix_valid), .pix_truecolor(pix_truecolor),
        .pix_index(pix_index), .pix_red(pix_red), .pix_green(pix_green),
        .pix_blue(pix_blue), .pix_ovl(pix_ovl), .underrun(underrun)
    );

    int checks = 0;
    int errors = 0;
    int under_cycles = 0;
    logic        prev_under = 1'b0;
    logic [40:0] expq[$];
    string       tagq[$];
    logic [40:0] last_item = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int bpp_of(input logic [3:0] m);
        case (m)
            4'd0: return 1;
            4'd1: return 2;
            4'd2: return 4;
            4'd4, 4'd5, 4'd6, 4'd7: return 16;
            4'd8: return 32;
            default: return 8;
        endcase
    endfunction

    // packed as {truecolor, index, red, green, blue, overlay}
    function automatic logic [40:0] exp_item(input logic [3:0] m, input bit be,
                                             input logic [7:0] pg, input logic [63:0] w, input int k);
        int bpp = bpp_of(m);
        int n = 64 / bpp;
        int slot = be ? (n - 1 - k) : k;
        logic [63:0] mask = (bpp == 32) ? 64'hFFFF_FFFF : ((64'd1 << bpp) - 64'd1);
        logic [31:0] p = 32'((w >> (slot * bpp)) & mask);
        logic [7:0] ix = 0, r = 0, g = 0, b = 0, o = 0;
        bit tc = (m >= 4 && m <= 8);
        case (m)
            4'd0: ix = {pg[7:1], p[0]};
            4'd1: ix = {pg[7:2], p[1:0]};
            4'd2: ix = {pg[7:4], p[3:0]};
            4'd4: begin r = {p[15:11], p[15:13]}; g = {p[10:5], p[10:9]}; b = {p[4:0], p[4:2]}; end
            4'd5: begin o = {8{p[15]}}; r = {p[14:10], p[14:12]}; g = {p[9:5], p[9:7]}; b = {p[4:0], p[4:2]}; end
            4'd6: begin r = {p[15:10], p[15:14]}; g = {p[9:4], p[9:8]}; b = {p[3:0], p[3:0]}; end
            4'd7: begin o = {p[15:12], p[15:12]}; r = {p[11:8], p[11:8]}; g = {p[7:4], p[7:4]}; b = {p[3:0], p[3:0]}; end
            4'd8: begin o = p[31:24]; r = p[23:16]; g = p[15:8]; b = p[7:0]; end
            default: ix = p[7:0];
        endcase
        return {tc, ix, r, g, b, o};
    endfunction

    // driver: called at a falling edge; pushes expectations then offers the word
    task automatic send(input logic [3:0] m, input bit be, input logic [63:0] w, input string tag);
        int n = 64 / bpp_of(m);
        for (int k = 0; k < n; k++) begin
            expq.push_back(exp_item(m, be, cfg_page, w, k));
            tagq.push_back(tag);
        end
        cfg_mode = m;
        cfg_big_endian = be;
        word_data = w;
        word_valid = 1'b1;
        while (!word_ready) @(negedge clk);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (!underrun);
        repeat (2) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            logic [40:0] cur;
            cur = {pix_truecolor, pix_index, pix_red, pix_green, pix_blue, pix_ovl};
            if (pix_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3", "pixel beyond word count", 64'(cur), 64'd0);
                end else begin
                    logic [40:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(cur == e, t, "pixel", 64'(cur), 64'(e));
                    last_item = e;
                end
            end
            if (underrun) begin
                under_cycles++;
                if (!prev_under)
                    chk(expq.size() == 0, "R3", "pixels missing at underrun", 64'(expq.size()), 64'd0);
            end
            prev_under = underrun;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", expq.size());
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        chk(word_ready && !pix_valid && !underrun, "R1", "in reset", {61'b0, word_ready, pix_valid, underrun}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_ready && !pix_valid && !underrun, "R1", "after reset", {61'b0, word_ready, pix_valid, underrun}, 64'h4);

        // pseudo-colour depths, both orders, with page bits
        cfg_page = 8'hA5;
        send(4'd0, 1'b0, 64'hF0E1_D2C3_B4A5_9687, "R4"); drain();
        send(4'd1, 1'b1, 64'h1B2C_3D4E_5F60_7182, "R5"); drain();
        cfg_page = 8'h3C;
        send(4'd2, 1'b0, 64'h0123_4567_89AB_CDEF, "R5"); drain();
        send(4'd3, 1'b1, 64'h0011_2233_4455_6677, "R4"); drain();
        send(4'd12, 1'b0, 64'h8899_AABB_CCDD_EEFF, "R3"); drain();

        // packed colour layouts, including all-ones fields
        send(4'd4, 1'b0, 64'hFFFF_0000_F800_07E0, "R6"); drain();
        send(4'd4, 1'b1, 64'h001F_A5A5_5A5A_FFFF, "R6"); drain();
        send(4'd5, 1'b1, 64'h8000_7FFF_FFFF_1234, "R7"); drain();
        send(4'd6, 1'b0, 64'hFC00_03F0_000F_FFFF, "R8"); drain();
        send(4'd7, 1'b1, 64'hF000_0F00_00F0_9ABC, "R9"); drain();
        send(4'd8, 1'b0, 64'h1122_3344_5566_7788, "R10"); drain();
        send(4'd8, 1'b1, 64'hFFEE_DDCC_BBAA_9988, "R10"); drain();

        // R12: held last pixel while starved
        repeat (4) @(negedge clk);
        chk(underrun && !pix_valid && word_ready, "R12", "starved flags",
            {61'b0, underrun, pix_valid, word_ready}, 64'h5);
        chk({pix_red, pix_green, pix_blue, pix_ovl} == last_item[31:0], "R12", "held pixel",
            64'({pix_red, pix_green, pix_blue, pix_ovl}), 64'(last_item[31:0]));

        // R11 and R13: back-to-back words changing format and order at the joint
        send(4'd7, 1'b0, 64'h1357_9BDF_2468_ACE0, "R11");
        snap = under_cycles;
        send(4'd3, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, "R13");
        send(4'd5, 1'b0, 64'h8421_7BDE_0000_FFFF, "R11");
        send(4'd0, 1'b1, 64'h5555_AAAA_0F0F_F0F0, "R13");
        while (expq.size() != 0) @(negedge clk);
        chk(under_cycles == snap, "R11", "gap in back-to-back stream", 64'(under_cycles), 64'(snap));
        drain();

        // R13: mode and order altered right after the load
        send(4'd4, 1'b0, 64'h0123_4567_89AB_CDEF, "R13");
        cfg_mode = 4'd1;
        cfg_big_endian = 1'b1;
        drain();

        // R2: one pixel per cycle, first pixel the cycle after the load
        send(4'd8, 1'b0, 64'hCAFE_BABE_0BAD_F00D, "R2");
        chk(pix_valid, "R2", "first pixel after load", 64'(pix_valid), 64'd1);
        @(negedge clk);
        chk(pix_valid, "R2", "second pixel", 64'(pix_valid), 64'd1);
        drain();

        chk(expq.size() == 0, "R3", "leftover expectations", 64'(expq.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule